// File: doc/BRIEF.md
# Link Self-Test Pattern Generator

This block drives a repeating stream of link control symbols onto every lane of a multi-lane serial link (up to eight lanes) while the link is under built-in self-test. It walks a small programmable buffer of control symbols and presents one symbol per lane per cycle. Each symbol comes with a control flag and a tag that gives the running disparity the encoder will apply to it. The encoder, the serializer, the receive-side checker and error reporting all sit outside this block.

Beyond replaying the buffer, the generator does three things. It inserts a skip ordered set on all lanes at a fixed interval, and software can suppress this. It replaces the head-of-buffer symbol on one chosen lane with a delay symbol, and can move that lane across the link after each buffer pass. It forces the disparity of the first symbol of every run, so each run produces the same pattern. Software writes a control byte and the buffer entries through a simple write port. A local start bit and a global start input are ORed together to run the generator.

The sequencer has three states. IDLE sends nothing and holds the counters at their start values. DATA sends buffer symbols. SKIP sends the skip ordered set. The transitions are:
- IDLE to DATA when run is high.
- DATA to SKIP when the skip interval expires and skips are not suppressed.
- SKIP to DATA after the last symbol of the ordered set.
- DATA or SKIP to IDLE whenever run is low.

Top module: `ltp_gen`

## Requirements
- R1: After reset, `tx_active`, every lane symbol, every control flag and every disparity tag are 0, and all control fields are 0. Every buffer entry resets to 0xBC, so `buf_bad` is 0, and the delay lane is lane 0.
- R2: Run equals control bit 0 OR `glob_start`. The cycle after run is first seen high, `tx_active` is 1 and the first symbol is on the lanes. The cycle after run is seen low, `tx_active` is 0.
- R3: While active and outside a skip set, every lane carries buffer entry i, with i cycling 0,1,..,BUF_DEPTH-1 and starting at 0, and every lane's control flag is 1. Buffer entry i is written at address i+1.
- R4: An entry is legal only if it is one of 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC, 0xF7, 0xFB, 0xFD or 0xFE. `buf_bad[i]` is 1 for each illegal entry, and 0xBC is transmitted in its place.
- R5: After 1180 buffer symbol times, all lanes carry a skip set of 0xBC followed by three 0x1C. The buffer then resumes at the index that follows the last one sent.
- R6: With control bit 6 (skip suppress) set to 1, no skip set is inserted.
- R7: The 3-bit lane field (control bits 5:3) selects a lane. While auto-sequencing (control bit 2) is 0, that lane carries 0xF7 in place of buffer entry 0 on every pass.
- R8: With auto-sequencing on, the delay lane starts at the programmed lane on each start. It advances by one after each full buffer pass and wraps from lane NUM_LANES-1 to lane 0.
- R9: The first symbol of a run carries disparity tag = control bit 1 (0 negative, 1 positive) on every lane. After that, a lane's tag inverts after each symbol in 0x3C, 0x5C, 0x7C, 0xBC or 0xDC, and stays the same after any other symbol.
- R10: Stopping and restarting resets the buffer index, the skip counter and the rotating lane, and forces the disparity again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | 0 = control byte, i+1 = buffer entry i |
| cfg_wdata | input | 8 | Write data |
| glob_start | input | 1 | Global start, ORed with the local start bit |
| tx_active | output | 1 | Stream is being driven |
| lane_sym | output | NUM_LANES*8 | Symbol per lane, lane n at bits n*8+7:n*8 |
| lane_k | output | NUM_LANES | Control-symbol flag per lane |
| lane_disp | output | NUM_LANES | Disparity tag per lane (1 = positive) |
| buf_bad | output | BUF_DEPTH | Illegal-entry flag per buffer entry |

## Verification
The checks of the start-up disparity assume that a write to the initial-disparity bit is registered before the run begins. The generator must load that bit at the same edge at which it leaves IDLE. The run-follow checks assume that `glob_start` and the write port change only between clock edges. The bench drives every input on the falling edge, so both assumptions hold. It updates the control byte only through complete write cycles, and it writes only the control address and the buffer addresses that exist.

// File: rtl/ltp_pkg.sv
package ltp_pkg;

    localparam logic [7:0] SYM_COM = 8'hBC;
    localparam logic [7:0] SYM_SKP = 8'h1C;
    localparam logic [7:0] SYM_DLY = 8'hF7;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_DATA = 2'd1,
        S_SKIP = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic       skip_sup;
        logic [2:0] lane;
        logic       auto_seq;
        logic       init_disp;
        logic       start;
    } ctrl_t;

    // legal control characters: the K28 family plus four x.7 codes
    function automatic logic is_ctrl_sym(input logic [7:0] s);
        logic ok;
        if (s[4:0] == 5'b11100)
            ok = 1'b1;
        else if (s[7:5] == 3'b111 &&
                 (s[4:0] == 5'b10111 || s[4:0] == 5'b11011 ||
                  s[4:0] == 5'b11101 || s[4:0] == 5'b11110))
            ok = 1'b1;
        else
            ok = 1'b0;
        return ok;
    endfunction

    // symbols whose encoded form is unbalanced and inverts running disparity
    function automatic logic flips_rd(input logic [7:0] s);
        logic f;
        f = (s[4:0] == 5'b11100) &&
            (s[7:5] == 3'd1 || s[7:5] == 3'd2 || s[7:5] == 3'd3 ||
             s[7:5] == 3'd5 || s[7:5] == 3'd6);
        return f;
    endfunction

endpackage

// File: rtl/ltp_regs.sv
module ltp_regs
    import ltp_pkg::*;
#(
    parameter  int BUF_DEPTH = 4,
    localparam int ADDR_W    = $clog2(BUF_DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [7:0]             wdata,
    output ctrl_t                  ctrl,
    output logic [BUF_DEPTH*8-1:0] buf_flat,
    output logic [BUF_DEPTH-1:0]   bad
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (we && addr == '0)
            ctrl_q <= ctrl_t'(wdata[6:0]);
    end

    assign ctrl = ctrl_q;

    for (genvar i = 0; i < BUF_DEPTH; i++) begin : g_ent
        logic [7:0] ent_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ent_q <= SYM_COM;
            else if (we && addr == ADDR_W'(i + 1))
                ent_q <= wdata;
        end

        assign bad[i]            = !is_ctrl_sym(ent_q);
        assign buf_flat[i*8 +: 8] = bad[i] ? SYM_COM : ent_q;
    end

endmodule

// File: rtl/ltp_seq.sv
module ltp_seq
    import ltp_pkg::*;
#(
    parameter  int NUM_LANES     = 8,
    parameter  int BUF_DEPTH     = 4,
    parameter  int SKIP_INTERVAL = 1180,
    parameter  int SKIP_LEN      = 4,
    localparam int IDX_W         = $clog2(BUF_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             skip_sup,
    input  logic             auto_seq,
    input  logic [2:0]       lane_cfg,
    output logic             active,
    output logic             in_skip,
    output logic             at_head,
    output logic             load_disp,
    output logic [IDX_W-1:0] idx,
    output logic [2:0]       dly_lane,
    output logic [7:0]       skip_sym
);

    localparam int CNT_W    = $clog2(SKIP_INTERVAL);
    localparam int POS_W    = $clog2(SKIP_LEN);
    localparam int LANE_MAX = NUM_LANES - 1;

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic [POS_W-1:0] pos_q;
    logic [2:0]       rot_q;
    logic             last_idx, skip_due, last_pos;

    assign last_idx = (idx_q == IDX_W'(BUF_DEPTH - 1));
    assign skip_due = !skip_sup && (cnt_q == CNT_W'(SKIP_INTERVAL - 1));
    assign last_pos = (pos_q == POS_W'(SKIP_LEN - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = run ? S_DATA : S_IDLE;
            S_DATA:  if (!run)         state_d = S_IDLE;
                     else if (skip_due) state_d = S_SKIP;
            S_SKIP:  if (!run)         state_d = S_IDLE;
                     else if (last_pos) state_d = S_DATA;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // index, interval counter, skip position and rotating lane
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            cnt_q <= '0;
            pos_q <= '0;
            rot_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    idx_q <= '0;
                    cnt_q <= '0;
                    pos_q <= '0;
                    rot_q <= lane_cfg;
                end
                S_DATA: begin
                    idx_q <= last_idx ? '0 : idx_q + 1'b1;
                    cnt_q <= (skip_due || skip_sup) ? '0 : cnt_q + 1'b1;
                    pos_q <= '0;
                    if (last_idx && auto_seq)
                        rot_q <= (rot_q >= 3'(LANE_MAX)) ? 3'd0 : rot_q + 3'd1;
                end
                S_SKIP: begin
                    pos_q <= pos_q + 1'b1;
                end
                default: begin
                    idx_q <= '0;
                    pos_q <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        active    = 1'b0;
        in_skip   = 1'b0;
        load_disp = 1'b0;
        unique case (state_q)
            S_IDLE:  load_disp = run;
            S_DATA:  active    = 1'b1;
            S_SKIP:  begin
                active  = 1'b1;
                in_skip = 1'b1;
            end
            default: active = 1'b0;
        endcase
    end

    assign at_head  = (idx_q == '0);
    assign idx      = idx_q;
    assign dly_lane = auto_seq ? rot_q : lane_cfg;
    assign skip_sym = (pos_q == '0) ? SYM_COM : SYM_SKP;

endmodule

// File: rtl/ltp_lane.sv
module ltp_lane
    import ltp_pkg::*;
#(
    parameter int LANE = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       in_skip,
    input  logic       at_head,
    input  logic       load_disp,
    input  logic       init_disp,
    input  logic [2:0] dly_lane,
    input  logic [7:0] data_sym,
    input  logic [7:0] skip_sym,
    output logic [7:0] sym,
    output logic       k,
    output logic       disp
);

    logic [7:0] sel;
    logic       disp_q;

    always_comb begin
        if (in_skip)
            sel = skip_sym;
        else if (at_head && dly_lane == 3'(LANE))
            sel = SYM_DLY;
        else
            sel = data_sym;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            disp_q <= 1'b0;
        else if (load_disp)
            disp_q <= init_disp;
        else if (active)
            disp_q <= disp_q ^ flips_rd(sel);
    end

    assign sym  = active ? sel : 8'h00;
    assign k    = active;
    assign disp = active & disp_q;

endmodule

// File: rtl/ltp_gen.sv
module ltp_gen
    import ltp_pkg::*;
#(
    parameter  int NUM_LANES     = 8,
    parameter  int BUF_DEPTH     = 4,
    parameter  int SKIP_INTERVAL = 1180,
    parameter  int SKIP_LEN      = 4,
    localparam int ADDR_W        = $clog2(BUF_DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [7:0]             cfg_wdata,
    input  logic                   glob_start,
    output logic                   tx_active,
    output logic [NUM_LANES*8-1:0] lane_sym,
    output logic [NUM_LANES-1:0]   lane_k,
    output logic [NUM_LANES-1:0]   lane_disp,
    output logic [BUF_DEPTH-1:0]   buf_bad
);

    localparam int IDX_W = $clog2(BUF_DEPTH);

    ctrl_t                  ctrl;
    logic [BUF_DEPTH*8-1:0] buf_flat;
    logic                   run, init_disp;
    logic                   active, in_skip, at_head, load_disp;
    logic [IDX_W-1:0]       idx;
    logic [2:0]             dly_lane;
    logic [7:0]             skip_sym, data_sym;

    ltp_regs #(.BUF_DEPTH(BUF_DEPTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .ctrl     (ctrl),
        .buf_flat (buf_flat),
        .bad      (buf_bad)
    );

    assign run       = ctrl.start | glob_start;
    assign init_disp = ctrl.init_disp;

    ltp_seq #(
        .NUM_LANES     (NUM_LANES),
        .BUF_DEPTH     (BUF_DEPTH),
        .SKIP_INTERVAL (SKIP_INTERVAL),
        .SKIP_LEN      (SKIP_LEN)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .skip_sup  (ctrl.skip_sup),
        .auto_seq  (ctrl.auto_seq),
        .lane_cfg  (ctrl.lane),
        .active    (active),
        .in_skip   (in_skip),
        .at_head   (at_head),
        .load_disp (load_disp),
        .idx       (idx),
        .dly_lane  (dly_lane),
        .skip_sym  (skip_sym)
    );

    assign data_sym  = buf_flat[{idx, 3'b000} +: 8];
    assign tx_active = active;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        ltp_lane #(.LANE(l)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .active    (active),
            .in_skip   (in_skip),
            .at_head   (at_head),
            .load_disp (load_disp),
            .init_disp (init_disp),
            .dly_lane  (dly_lane),
            .data_sym  (data_sym),
            .skip_sym  (skip_sym),
            .sym       (lane_sym[l*8 +: 8]),
            .k         (lane_k[l]),
            .disp      (lane_disp[l])
        );
    end

endmodule

// File: rtl/ltp_gen_chk.sv
module ltp_gen_chk
    import ltp_pkg::*;
#(
    parameter int NUM_LANES = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   run,
    input logic                   init_disp,
    input logic                   tx_active,
    input logic [NUM_LANES*8-1:0] lane_sym,
    input logic [NUM_LANES-1:0]   lane_k,
    input logic [NUM_LANES-1:0]   lane_disp
);

    AST_RUN_TO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> tx_active); // R2

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tx_active); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> (lane_sym == '0 && lane_k == '0 && lane_disp == '0)); // R1

    AST_K_ON_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |-> (&lane_k)); // R3

    AST_START_DISP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active) |-> lane_disp == {NUM_LANES{$past(init_disp)}}); // R9

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_legal
        AST_LEGAL_SYM: assert property (@(posedge clk) disable iff (!rst_n)
            tx_active |-> is_ctrl_sym(lane_sym[l*8 +: 8])); // R4
    end

endmodule

bind ltp_gen ltp_gen_chk #(.NUM_LANES(NUM_LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .init_disp (init_disp),
    .tx_active (tx_active),
    .lane_sym  (lane_sym),
    .lane_k    (lane_k),
    .lane_disp (lane_disp)
);

// File: tb/sim_ltp_gen.sv
module sim_ltp_gen;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 8;
    localparam int DEPTH      = 4;
    localparam int AW         = 3;
    localparam int INTERVAL   = 1180;
    localparam int SLEN       = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cfg_we = 1'b0;
    logic [AW-1:0]        cfg_addr = '0;
    logic [7:0]           cfg_wdata = '0;
    logic                 glob_start = 1'b0;
    logic                 tx_active;
    logic [LANES*8-1:0]   lane_sym;
    logic [LANES-1:0]     lane_k;
    logic [LANES-1:0]     lane_disp;
    logic [DEPTH-1:0]     buf_bad;

    int total = 0;
    int bad   = 0;
    logic [7:0] bufm [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    ltp_gen #(
        .NUM_LANES(LANES), .BUF_DEPTH(DEPTH),
        .SKIP_INTERVAL(INTERVAL), .SKIP_LEN(SLEN)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .glob_start(glob_start), .tx_active(tx_active),
        .lane_sym(lane_sym), .lane_k(lane_k), .lane_disp(lane_disp),
        .buf_bad(buf_bad)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sym_at(input int lane);
        return lane_sym[lane*8 +: 8];
    endfunction

    function automatic logic flip_exp(input logic [7:0] s);
        return s == 8'h3C || s == 8'h5C || s == 8'h7C || s == 8'hBC || s == 8'hDC;
    endfunction

    function automatic logic [7:0] data_exp(input int lane, input int c, input int dl);
        int i;
        i = c % DEPTH;
        if (i == 0 && lane == dl) return 8'hF7;
        return bufm[i];
    endfunction

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_ctrl(input logic st, input logic ini, input logic au,
                            input logic [2:0] ln, input logic sup);
        wr(0, {1'b0, sup, ln, au, ini, st});
    endtask

    task automatic load_buf(input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input logic [7:0] b3);
        bufm[0] = b0; bufm[1] = b1; bufm[2] = b2; bufm[3] = b3;
        for (int i = 0; i < DEPTH; i++) wr(i + 1, bufm[i]);
    endtask

    task automatic stop_run();
        set_ctrl(1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
        glob_start = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 tx_active", tx_active, 0);
        chk("R1 lane_sym", lane_sym, 0);
        chk("R1 lane_k/disp", {lane_k, lane_disp}, 0);
        chk("R1 buf_bad", buf_bad, 0);
        @(negedge clk); glob_start = 1'b1;
        @(negedge clk);
        chk("R1 reset entry on lane 3", sym_at(3), 8'hBC);
        chk("R1 default delay lane 0", sym_at(0), 8'hF7);
        stop_run();
    endtask

    task automatic t_basic();
        int errs;
        errs = 0;
        load_buf(8'h1C, 8'hFB, 8'hFD, 8'hFE);
        set_ctrl(1'b1, 1'b0, 1'b0, 3'd5, 1'b0);
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            for (int l = 0; l < LANES; l++)
                if (sym_at(l) !== data_exp(l, c, 5)) errs++;
            if (lane_k !== 8'hFF) errs++;
        end
        chk("R3 R7 buffer cycling with delay on lane 5", errs, 0);
        set_ctrl(1'b0, 1'b0, 1'b0, 3'd5, 1'b0);
        @(negedge clk);
        chk("R2 stop via local bit", tx_active, 0);
    endtask

    task automatic t_glob();
        @(negedge clk); glob_start = 1'b1;
        @(negedge clk);
        chk("R2 global start active", tx_active, 1);
        chk("R2 global start first symbol", sym_at(1), bufm[0]);
        glob_start = 1'b0;
        @(negedge clk);
        chk("R2 global stop idle", tx_active, 0);
    endtask

    task automatic t_bad();
        wr(3, 8'h00);
        wr(4, 8'hBD);
        chk("R4 bad flags", buf_bad, 4'b1100);
        set_ctrl(1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R4 entry 2 replaced", sym_at(3), 8'hBC);
        @(negedge clk);
        chk("R4 entry 3 replaced", sym_at(3), 8'hBC);
        stop_run();
        load_buf(8'h1C, 8'hFB, 8'hFD, 8'hFE);
        chk("R4 flags clear after rewrite", buf_bad, 0);
    endtask

    task automatic t_disp();
        logic t2, t7;
        int errs;
        logic [7:0] s;
        errs = 0;
        load_buf(8'hBC, 8'hBC, 8'h1C, 8'hDC);
        set_ctrl(1'b1, 1'b1, 1'b0, 3'd7, 1'b0);
        t2 = 1'b1; t7 = 1'b1;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (lane_disp[2] !== t2) errs++;
            if (lane_disp[7] !== t7) errs++;
            s = data_exp(2, c, 7); t2 = t2 ^ flip_exp(s);
            s = data_exp(7, c, 7); t7 = t7 ^ flip_exp(s);
        end
        chk("R9 disparity tags from positive start", errs, 0);
        stop_run();
        set_ctrl(1'b1, 1'b0, 1'b0, 3'd7, 1'b0);
        @(negedge clk);
        chk("R10 R9 disparity forced negative on restart", lane_disp, 0);
        chk("R10 index back to 0", sym_at(2), bufm[0]);
        @(negedge clk);
        chk("R9 tag after 0xBC inverts", lane_disp[2], 1);
        stop_run();
    endtask

    task automatic t_auto();
        int errs, dl;
        errs = 0;
        load_buf(8'h7C, 8'h9C, 8'hFC, 8'hFE);
        set_ctrl(1'b1, 1'b0, 1'b1, 3'd6, 1'b0);
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            dl = (6 + c / DEPTH) % LANES;
            for (int l = 0; l < LANES; l++)
                if (sym_at(l) !== data_exp(l, c, dl)) errs++;
        end
        chk("R8 delay lane rotates 6,7,0,1", errs, 0);
        set_ctrl(1'b0, 1'b0, 1'b1, 3'd6, 1'b0);
        @(negedge clk);
        set_ctrl(1'b1, 1'b0, 1'b1, 3'd6, 1'b0);
        @(negedge clk);
        chk("R10 rotation restarts at lane 6", sym_at(6), 8'hF7);
        chk("R8 lane 0 plain after restart", sym_at(0), 8'h7C);
        stop_run();
    endtask

    task automatic t_skip();
        int errs;
        logic [7:0] e;
        errs = 0;
        load_buf(8'h7C, 8'h9C, 8'hFC, 8'hFE);
        set_ctrl(1'b1, 1'b0, 1'b0, 3'd5, 1'b0);
        for (int c = 0; c < INTERVAL + SLEN + 8; c++) begin
            @(negedge clk);
            if (c < INTERVAL)               e = data_exp(1, c, 5);
            else if (c == INTERVAL)         e = 8'hBC;
            else if (c < INTERVAL + SLEN)   e = 8'h1C;
            else                            e = data_exp(1, c - SLEN, 5);
            if (sym_at(1) !== e) errs++;
            if (c == INTERVAL + 1)
                chk("R5 skip symbol on all lanes", lane_sym, {LANES{8'h1C}});
            if (c == INTERVAL + SLEN)
                chk("R5 resume at head with delay lane 5", sym_at(5), 8'hF7);
        end
        chk("R5 skip set position and resume", errs, 0);
        stop_run();
    endtask

    task automatic t_suppress();
        int errs;
        errs = 0;
        set_ctrl(1'b1, 1'b0, 1'b0, 3'd5, 1'b1);
        for (int c = 0; c < INTERVAL + 20; c++) begin
            @(negedge clk);
            if (sym_at(1) !== data_exp(1, c, 5)) errs++;
        end
        chk("R6 no skip set when suppressed", errs, 0);
        stop_run();
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) bufm[i] = 8'hBC;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_glob();
        t_bad();
        t_disp();
        t_auto();
        t_skip();
        t_suppress();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule